// File: doc/BRIEF.md
# Vector Instruction Format Decoder

This block sits in the decode stage of a vector shader core. It accepts a 64-bit instruction window and a generation-select input. From the window it recognises one of two vector arithmetic encodings. The first is a 32-bit short form, which names two sources and one vector destination. The second is a 64-bit long form, which names three sources, a vector destination and result/source modifiers. Only the low dword of the window matters for the short form; the high dword is ignored. The block does not execute anything, and it does not fetch a trailing literal dword.

Both encodings are reported in one opcode space, the long-form numbering, with short-form opcodes mirrored into 256..319. All sources are reported in a single 9-bit operand code. In that code, 0..103 are scalar registers, 124 is the M0 register, 254 is LDS-direct, 255 is an inline literal and 256..511 are vector registers. The code points are parameters. A legality checker applies cross-operand rules to the sources the instruction actually reads: a limit on the scalar bus, literal exclusivity and LDS-direct placement. All outputs pass through an optional output register, which is enabled by default.

Top module: `vec_fmt_decoder`

## Requirements
- R1: When bit 31 is 0 the word is a short form. The outputs are is_short=1, instr_len=1, opcode=256+bits[30:25], vdst=bits[24:17], src0=bits[8:0] and src1=256+bits[16:9]. src2, sdst, abs_mod, clamp, omod and neg are 0, and bits[63:32] have no effect.
- R2: When bits[31:26]=6'b110100 the word is a long form. The outputs are is_long=1, instr_len=2, vdst=bits[7:0], src0=bits[40:32], src1=bits[49:41], src2=bits[58:50], omod=bits[60:59] and neg=bits[63:61].
- R3: With gen_new=0 the long-form opcode is bits[25:17], zero-extended to 10 bits. With carry_form=0, clamp=bit 11, abs_mod=bits[10:8] and sdst=0. With carry_form=1, sdst=bits[14:8], clamp=bit 15 and abs_mod=0.
- R4: With gen_new=1 the long-form opcode is bits[25:16] and clamp=bit 15. With carry_form=0, abs_mod=bits[10:8] and sdst=0. With carry_form=1, sdst=bits[14:8] and abs_mod=0.
- R5: A word that matches neither form gives invalid=1 and instr_len=1. Every other output is 0, including illegal and needs_literal.
- R6: A short form reads src0 and src1. A long form reads src0 and src1, and reads src2 only when its opcode lies outside 256..319. A source that is not read takes no part in R7 to R9.
- R7: If the sources read contain more than one distinct scalar code (0..103 or 124), illegal=1. The same scalar code repeated is legal.
- R8: If any source read is 255, needs_literal=1. If that source appears together with any scalar code among the sources read, illegal=1.
- R9: If code 254 appears in src1, or in src2 when src2 is read, illegal=1. Code 254 in src0 is legal.
- R10: All outputs are registered. They change one clock edge after the inputs, and they are all 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_win | input | 64 | Instruction window; the low dword is the first dword |
| gen_new | input | 1 | 1 selects the newer long-form field layout |
| carry_form | input | 1 | 1 selects the long-form variant that carries a scalar destination |
| is_short | output | 1 | Short form recognised |
| is_long | output | 1 | Long form recognised |
| invalid | output | 1 | Neither form matched |
| instr_len | output | 2 | Encoding length in dwords |
| opcode | output | 10 | Opcode normalised to the long-form space |
| vdst | output | 8 | Vector destination |
| sdst | output | 7 | Scalar destination (carry variant) |
| src0 | output | 9 | First source code |
| src1 | output | 9 | Second source code |
| src2 | output | 9 | Third source code |
| abs_mod | output | 3 | Absolute-value flags per source |
| clamp | output | 1 | Result clamp flag |
| omod | output | 2 | Output multiplier field |
| neg | output | 3 | Negation flags per source |
| needs_literal | output | 1 | A literal dword follows |
| illegal | output | 1 | An operand constraint is broken |

## Verification
On every cycle, the assertions check that exactly one form flag is set, that a long form always reports two dwords, and that a short-form opcode always lands in the mirrored range. They also check that an invalid word raises no operand flags, and that a short form using a literal is never flagged. Field positions can only be shown by the bench's scenarios. These cover the two generations and two long-form variants, the role of src2 depending on the opcode, the difference between a repeated and a distinct scalar register, and the one-edge latency of the output register. A reference function computes the expected outputs for random and directed words.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

   localparam int WIN_W  = 64;
   localparam int SRC_W  = 9;
   localparam int OP_W   = 10;
   localparam int VDST_W = 8;
   localparam int SDST_W = 7;
   localparam int NSRC   = 3;
   localparam int LEN_W  = 2;

   typedef enum logic [1:0] {
      FMT_NONE  = 2'd0,
      FMT_SHORT = 2'd1,
      FMT_LONG  = 2'd2
   } fmt_e;

   typedef struct packed {
      logic                is_short;
      logic                is_long;
      logic                invalid;
      logic [LEN_W-1:0]    len;
      logic [OP_W-1:0]     opcode;
      logic [VDST_W-1:0]   vdst;
      logic [SDST_W-1:0]   sdst;
      logic [SRC_W-1:0]    src0;
      logic [SRC_W-1:0]    src1;
      logic [SRC_W-1:0]    src2;
      logic [NSRC-1:0]     absm;
      logic                clamp;
      logic [1:0]          omod;
      logic [NSRC-1:0]     neg;
      logic                needs_lit;
      logic                illegal;
   } dec_t;

endpackage

// File: rtl/vdec_form_detect.sv
module vdec_form_detect #(
   parameter int               TAG_W    = 6,
   parameter logic [TAG_W-1:0] LONG_TAG = 6'b110100
) (
   input  logic [TAG_W-1:0] tag_bits,
   output vdec_pkg::fmt_e   fmt
);
   import vdec_pkg::*;

   localparam int TOP = TAG_W - 1;

   // The short form is told apart by its top bit, so the long tag must set it.
   if (LONG_TAG[TOP] != 1'b1) begin : g_bad_tag
      $error("vdec_form_detect: LONG_TAG must have its top bit set");
   end
   if (TAG_W < 2) begin : g_bad_width
      $error("vdec_form_detect: TAG_W too small");
   end

   always_comb begin
      if (!tag_bits[TOP])
         fmt = FMT_SHORT;
      else if (tag_bits == LONG_TAG)
         fmt = FMT_LONG;
      else
         fmt = FMT_NONE;
   end

endmodule

// File: rtl/vdec_field_extract.sv
module vdec_field_extract #(
   parameter int VREG_BASE   = 256,
   parameter int MIRROR_BASE = 256,
   parameter int MIRROR_SIZE = 64
) (
   input  vdec_pkg::fmt_e                                 fmt,
   input  logic                                           gen_new,
   input  logic                                           carry_form,
   input  logic [30:0]                                    lo_body,
   input  logic [31:0]                                    hi_word,
   output logic [vdec_pkg::OP_W-1:0]                      opcode,
   output logic [vdec_pkg::VDST_W-1:0]                    vdst,
   output logic [vdec_pkg::SDST_W-1:0]                    sdst,
   output logic [vdec_pkg::NSRC-1:0][vdec_pkg::SRC_W-1:0] srcs,
   output logic [vdec_pkg::NSRC-1:0]                      absm,
   output logic                                           clamp,
   output logic [1:0]                                     omod,
   output logic [vdec_pkg::NSRC-1:0]                      neg,
   output logic [vdec_pkg::NSRC-1:0]                      use_mask,
   output logic [vdec_pkg::LEN_W-1:0]                     len
);
   import vdec_pkg::*;

   // Short-form bit positions
   localparam int S_SRC0_LSB = 0;
   localparam int S_VS1_LSB  = 9;
   localparam int S_VS1_W    = 8;
   localparam int S_VDST_LSB = 17;
   localparam int S_OP_LSB   = 25;
   localparam int S_OP_W     = 6;
   // Long-form bit positions (hi_word is relative to bit 32)
   localparam int L_VDST_LSB = 0;
   localparam int L_MID_LSB  = 8;
   localparam int L_ABS_LSB  = 8;
   localparam int L_OLD_CLMP = 11;
   localparam int L_CLMP_B   = 15;
   localparam int L_OPN_LSB  = 16;
   localparam int L_OPO_LSB  = 17;
   localparam int L_OPO_W    = 9;
   localparam int L_OMOD_LSB = SRC_W * NSRC;
   localparam int L_NEG_LSB  = L_OMOD_LSB + 2;

   localparam logic [SRC_W-1:0] VBASE_C = SRC_W'(VREG_BASE);
   localparam logic [OP_W-1:0]  MBASE_C = OP_W'(MIRROR_BASE);
   localparam logic [OP_W-1:0]  MLAST_C = OP_W'(MIRROR_BASE + MIRROR_SIZE - 1);

   if (MIRROR_SIZE != (1 << S_OP_W)) begin : g_bad_mirror
      $error("vdec_field_extract: MIRROR_SIZE must cover the short opcode field");
   end
   if (VREG_BASE + (1 << S_VS1_W) > (1 << SRC_W)) begin : g_bad_vbase
      $error("vdec_field_extract: vector register range exceeds source code space");
   end
   if (L_NEG_LSB + NSRC != 32) begin : g_bad_hi
      $error("vdec_field_extract: long-form high dword layout does not fit");
   end

   // Long-form source fields are packed back to back in the high dword.
   logic [NSRC-1:0][SRC_W-1:0] long_src;
   for (genvar i = 0; i < NSRC; i++) begin : g_lsrc
      assign long_src[i] = hi_word[i*SRC_W +: SRC_W];
   end

   logic [OP_W-1:0] long_op;
   logic            in_mirror;

   always_comb begin
      if (gen_new)
         long_op = lo_body[L_OPN_LSB +: OP_W];
      else
         long_op = OP_W'(lo_body[L_OPO_LSB +: L_OPO_W]);
   end

   assign in_mirror = (long_op >= MBASE_C) && (long_op <= MLAST_C);

   always_comb begin
      opcode   = '0;
      vdst     = '0;
      sdst     = '0;
      srcs     = '0;
      absm     = '0;
      clamp    = 1'b0;
      omod     = '0;
      neg      = '0;
      use_mask = '0;
      len      = LEN_W'(1);
      unique case (fmt)
         FMT_SHORT: begin
            opcode   = MBASE_C + OP_W'(lo_body[S_OP_LSB +: S_OP_W]);
            vdst     = lo_body[S_VDST_LSB +: VDST_W];
            srcs[0]  = lo_body[S_SRC0_LSB +: SRC_W];
            srcs[1]  = VBASE_C + SRC_W'(lo_body[S_VS1_LSB +: S_VS1_W]);
            use_mask = NSRC'(3);
         end
         FMT_LONG: begin
            opcode = long_op;
            vdst   = lo_body[L_VDST_LSB +: VDST_W];
            srcs   = long_src;
            omod   = hi_word[L_OMOD_LSB +: 2];
            neg    = hi_word[L_NEG_LSB +: NSRC];
            len    = LEN_W'(2);
            if (carry_form) begin
               sdst  = lo_body[L_MID_LSB +: SDST_W];
               clamp = lo_body[L_CLMP_B];
            end else begin
               absm  = lo_body[L_ABS_LSB +: NSRC];
               clamp = gen_new ? lo_body[L_CLMP_B] : lo_body[L_OLD_CLMP];
            end
            use_mask = {~in_mirror, 2'b11};
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/vdec_operand_check.sv
module vdec_operand_check #(
   parameter int SCAL_LAST = 103,
   parameter int M0_CODE   = 124,
   parameter int LDSD_CODE = 254,
   parameter int LIT_CODE  = 255
) (
   input  logic [vdec_pkg::NSRC-1:0][vdec_pkg::SRC_W-1:0] srcs,
   input  logic [vdec_pkg::NSRC-1:0]                      use_mask,
   output logic                                           needs_lit,
   output logic                                           illegal
);
   import vdec_pkg::*;

   localparam logic [SRC_W-1:0] SLAST_C = SRC_W'(SCAL_LAST);
   localparam logic [SRC_W-1:0] M0_C    = SRC_W'(M0_CODE);
   localparam logic [SRC_W-1:0] LDSD_C  = SRC_W'(LDSD_CODE);
   localparam logic [SRC_W-1:0] LIT_C   = SRC_W'(LIT_CODE);

   if (SCAL_LAST >= M0_CODE || M0_CODE >= LDSD_CODE || LDSD_CODE == LIT_CODE) begin : g_bad_codes
      $error("vdec_operand_check: operand class codes overlap or are out of order");
   end
   if (LIT_CODE >= (1 << SRC_W)) begin : g_bad_lit
      $error("vdec_operand_check: literal code exceeds source width");
   end

   logic [NSRC-1:0] is_scal, is_lit, is_lds;

   for (genvar i = 0; i < NSRC; i++) begin : g_class
      assign is_scal[i] = use_mask[i] && ((srcs[i] <= SLAST_C) || (srcs[i] == M0_C));
      assign is_lit[i]  = use_mask[i] && (srcs[i] == LIT_C);
      assign is_lds[i]  = use_mask[i] && (srcs[i] == LDSD_C);
   end

   logic scal_multi;
   always_comb begin
      scal_multi = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         for (int j = i + 1; j < NSRC; j++) begin
            if (is_scal[i] && is_scal[j] && (srcs[i] != srcs[j]))
               scal_multi = 1'b1;
         end
      end
   end

   logic lit_clash, lds_misplaced;
   assign needs_lit     = |is_lit;
   assign lit_clash     = needs_lit && (|is_scal);
   assign lds_misplaced = |is_lds[NSRC-1:1];
   assign illegal       = scal_multi || lit_clash || lds_misplaced;

endmodule

// File: rtl/vec_fmt_decoder.sv
module vec_fmt_decoder #(
   parameter bit OUT_REG     = 1'b1,
   parameter int VREG_BASE   = 256,
   parameter int MIRROR_BASE = 256,
   parameter int SCAL_LAST   = 103,
   parameter int M0_CODE     = 124,
   parameter int LDSD_CODE   = 254,
   parameter int LIT_CODE    = 255
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [63:0] instr_win,
   input  logic        gen_new,
   input  logic        carry_form,
   output logic        is_short,
   output logic        is_long,
   output logic        invalid,
   output logic [1:0]  instr_len,
   output logic [9:0]  opcode,
   output logic [7:0]  vdst,
   output logic [6:0]  sdst,
   output logic [8:0]  src0,
   output logic [8:0]  src1,
   output logic [8:0]  src2,
   output logic [2:0]  abs_mod,
   output logic        clamp,
   output logic [1:0]  omod,
   output logic [2:0]  neg,
   output logic        needs_literal,
   output logic        illegal
);
   import vdec_pkg::*;

   localparam int TAG_W   = 6;
   localparam int TAG_LSB = 32 - TAG_W;
   localparam logic [SRC_W-1:0] LIT_C = SRC_W'(LIT_CODE);

   if (WIN_W != 64) begin : g_bad_win
      $error("vec_fmt_decoder: window width must be two dwords");
   end

   fmt_e                       fmt;
   logic [OP_W-1:0]            f_op;
   logic [VDST_W-1:0]          f_vdst;
   logic [SDST_W-1:0]          f_sdst;
   logic [NSRC-1:0][SRC_W-1:0] f_srcs;
   logic [NSRC-1:0]            f_abs, f_neg, f_use;
   logic                       f_clamp;
   logic [1:0]                 f_omod;
   logic [LEN_W-1:0]           f_len;
   logic                       c_lit, c_illegal;

   vdec_form_detect #(
      .TAG_W    (TAG_W),
      .LONG_TAG (6'b110100)
   ) u_detect (
      .tag_bits (instr_win[31:TAG_LSB]),
      .fmt      (fmt)
   );

   vdec_field_extract #(
      .VREG_BASE   (VREG_BASE),
      .MIRROR_BASE (MIRROR_BASE),
      .MIRROR_SIZE (64)
   ) u_fields (
      .fmt        (fmt),
      .gen_new    (gen_new),
      .carry_form (carry_form),
      .lo_body    (instr_win[30:0]),
      .hi_word    (instr_win[63:32]),
      .opcode     (f_op),
      .vdst       (f_vdst),
      .sdst       (f_sdst),
      .srcs       (f_srcs),
      .absm       (f_abs),
      .clamp      (f_clamp),
      .omod       (f_omod),
      .neg        (f_neg),
      .use_mask   (f_use),
      .len        (f_len)
   );

   vdec_operand_check #(
      .SCAL_LAST (SCAL_LAST),
      .M0_CODE   (M0_CODE),
      .LDSD_CODE (LDSD_CODE),
      .LIT_CODE  (LIT_CODE)
   ) u_check (
      .srcs      (f_srcs),
      .use_mask  (f_use),
      .needs_lit (c_lit),
      .illegal   (c_illegal)
   );

   dec_t dec_c, dec_o;

   always_comb begin
      dec_c           = '0;
      dec_c.is_short  = (fmt == FMT_SHORT);
      dec_c.is_long   = (fmt == FMT_LONG);
      dec_c.invalid   = (fmt == FMT_NONE);
      dec_c.len       = f_len;
      dec_c.opcode    = f_op;
      dec_c.vdst      = f_vdst;
      dec_c.sdst      = f_sdst;
      dec_c.src0      = f_srcs[0];
      dec_c.src1      = f_srcs[1];
      dec_c.src2      = f_srcs[2];
      dec_c.absm      = f_abs;
      dec_c.clamp     = f_clamp;
      dec_c.omod      = f_omod;
      dec_c.neg       = f_neg;
      dec_c.needs_lit = c_lit;
      dec_c.illegal   = c_illegal;
   end

   if (OUT_REG) begin : g_reg
      dec_t dec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dec_q <= '0;
         else        dec_q <= dec_c;
      end
      assign dec_o = dec_q;
   end else begin : g_comb
      assign dec_o = dec_c;
   end

   assign is_short      = dec_o.is_short;
   assign is_long       = dec_o.is_long;
   assign invalid       = dec_o.invalid;
   assign instr_len     = dec_o.len;
   assign opcode        = dec_o.opcode;
   assign vdst          = dec_o.vdst;
   assign sdst          = dec_o.sdst;
   assign src0          = dec_o.src0;
   assign src1          = dec_o.src1;
   assign src2          = dec_o.src2;
   assign abs_mod       = dec_o.absm;
   assign clamp         = dec_o.clamp;
   assign omod          = dec_o.omod;
   assign neg           = dec_o.neg;
   assign needs_literal = dec_o.needs_lit;
   assign illegal       = dec_o.illegal;

   AST_ONE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({dec_c.is_short, dec_c.is_long, dec_c.invalid})); // R5
   AST_LONG_TWO_DWORDS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_c.is_long |-> (dec_c.len == 2'd2)); // R2
   AST_SHORT_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
      dec_c.is_short |-> (dec_c.opcode >= OP_W'(MIRROR_BASE) && dec_c.opcode < OP_W'(MIRROR_BASE + 64))); // R1
   AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      dec_c.invalid |-> (!dec_c.illegal && !dec_c.needs_lit && dec_c.len == 2'd1)); // R5
   AST_SHORT_LIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_c.is_short && dec_c.src0 == LIT_C) |-> (dec_c.needs_lit && !dec_c.illegal)); // R8

endmodule

// File: tb/tb_vec_fmt_decoder.sv
module tb_vec_fmt_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] instr_win = '0;
   logic        gen_new = 1'b0;
   logic        carry_form = 1'b0;
   logic        is_short, is_long, invalid, clamp, needs_literal, illegal;
   logic [1:0]  instr_len, omod;
   logic [9:0]  opcode;
   logic [7:0]  vdst;
   logic [6:0]  sdst;
   logic [8:0]  src0, src1, src2;
   logic [2:0]  abs_mod, neg;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   vec_fmt_decoder dut (
      .clk(clk), .rst_n(rst_n), .instr_win(instr_win), .gen_new(gen_new),
      .carry_form(carry_form), .is_short(is_short), .is_long(is_long),
      .invalid(invalid), .instr_len(instr_len), .opcode(opcode), .vdst(vdst),
      .sdst(sdst), .src0(src0), .src1(src1), .src2(src2), .abs_mod(abs_mod),
      .clamp(clamp), .omod(omod), .neg(neg), .needs_literal(needs_literal),
      .illegal(illegal)
   );

   wire [67:0] got = {is_short, is_long, invalid, instr_len, opcode, vdst, sdst,
                      src0, src1, src2, abs_mod, clamp, omod, neg, needs_literal, illegal};

   function automatic logic is_scalar(logic [8:0] c);
      return (c <= 9'd103) || (c == 9'd124);
   endfunction

   // Expected outputs from the requirements, same field order as got.
   function automatic logic [67:0] ref_dec(logic [63:0] w, logic g, logic cf);
      logic sh = 0, lg = 0, inv = 0, cl = 0, lit, bad;
      logic [1:0] len = 2'd1, om = 0;
      logic [9:0] op = 0;
      logic [7:0] vd = 0;
      logic [6:0] sd = 0;
      logic [8:0] s0 = 0, s1 = 0, s2 = 0;
      logic [2:0] ab = 0, ng = 0;
      logic use2 = 0;
      logic [8:0] s[3];
      logic u[3];
      if (!w[31]) begin
         sh = 1; op = 10'd256 + {4'd0, w[30:25]}; vd = w[24:17];
         s0 = w[8:0]; s1 = {1'b1, w[16:9]};
      end else if (w[31:26] == 6'b110100) begin
         lg = 1; len = 2'd2; vd = w[7:0];
         s0 = w[40:32]; s1 = w[49:41]; s2 = w[58:50]; om = w[60:59]; ng = w[63:61];
         op = g ? w[25:16] : {1'b0, w[25:17]};
         if (cf) begin sd = w[14:8]; cl = w[15]; end
         else begin ab = w[10:8]; cl = g ? w[15] : w[11]; end
         use2 = (op < 10'd256) || (op > 10'd319);
      end else begin
         inv = 1;
      end
      s[0] = s0; s[1] = s1; s[2] = s2;
      u[0] = sh | lg; u[1] = sh | lg; u[2] = use2;
      lit = 0; bad = 0;
      for (int i = 0; i < 3; i++) if (u[i] && s[i] == 9'd255) lit = 1;
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 3; j++)
            if (u[i] && u[j] && is_scalar(s[i]) && is_scalar(s[j]) && s[i] != s[j]) bad = 1;
      for (int i = 0; i < 3; i++) if (lit && u[i] && is_scalar(s[i])) bad = 1;
      for (int i = 1; i < 3; i++) if (u[i] && s[i] == 9'd254) bad = 1;
      return {sh, lg, inv, len, op, vd, sd, s0, s1, s2, ab, cl, om, ng, lit, bad};
   endfunction

   function automatic logic [63:0] mk_long(logic [9:0] f2516, logic b15, logic [6:0] b148,
                                           logic [7:0] vd, logic [8:0] s0, logic [8:0] s1,
                                           logic [8:0] s2, logic [1:0] om, logic [2:0] ng);
      return {ng, om, s2, s1, s0, 6'b110100, f2516, b15, b148, vd};
   endfunction

   function automatic logic [63:0] mk_short(logic [5:0] op, logic [7:0] vd,
                                            logic [7:0] vs1, logic [8:0] s0);
      return {32'hDEAD_BEEF, 1'b0, op, vd, vs1, s0};
   endfunction

   task automatic check_vec(string req, logic [67:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h (win %h)", req, got, exp, instr_win);
      end
   endtask

   task automatic apply(string req, logic [63:0] w, logic g, logic cf);
      @(negedge clk);
      instr_win = w; gen_new = g; carry_form = cf;
      @(posedge clk);
      #1;
      check_vec(req, ref_dec(w, g, cf));
   endtask

   function automatic logic [8:0] pick_src();
      case ($urandom % 8)
         0: return 9'($urandom % 104);
         1: return 9'd124;
         2: return 9'd255;
         3: return 9'd254;
         default: return 9'd256 + 9'($urandom % 256);
      endcase
   endfunction

   initial begin
      #2_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [63:0] w;
      void'($urandom(32'd20240611));
      instr_win = mk_short(6'd3, 8'd7, 8'd9, 9'd5);
      repeat (3) @(posedge clk);
      #1;
      check_vec("R10 reset", '0);
      @(negedge clk);
      rst_n = 1'b1;

      apply("R1 short basic", mk_short(6'd3, 8'd7, 8'd9, 9'd5), 1'b0, 1'b0);
      apply("R1 short top opcode", mk_short(6'd63, 8'hFF, 8'hFF, 9'd300), 1'b1, 1'b1);
      apply("R8 short literal", mk_short(6'd1, 8'd2, 8'd3, 9'd255), 1'b0, 1'b0);
      apply("R9 short lds src0", mk_short(6'd1, 8'd2, 8'd3, 9'd254), 1'b0, 1'b0);
      apply("R3 old gen plain", mk_long({9'h103, 1'b1}, 1'b1, 7'b0001101, 8'd4,
            9'd257, 9'd258, 9'd0, 2'd2, 3'd5), 1'b0, 1'b0);
      apply("R3 old gen carry", mk_long({9'h11C, 1'b0}, 1'b1, 7'h55, 8'd6,
            9'd260, 9'd261, 9'd270, 2'd1, 3'd2), 1'b0, 1'b1);
      apply("R4 new gen plain", mk_long(10'h105, 1'b1, 7'b0000110, 8'd9,
            9'd300, 9'd301, 9'd302, 2'd3, 3'd7), 1'b1, 1'b0);
      apply("R4 new gen carry", mk_long(10'h11D, 1'b0, 7'h2A, 8'd1,
            9'd256, 9'd257, 9'd258, 2'd0, 3'd1), 1'b1, 1'b1);
      apply("R7 two scalars", mk_long(10'h105, 1'b0, 7'd0, 8'd0,
            9'd3, 9'd7, 9'd256, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R7 same scalar", mk_long(10'h105, 1'b0, 7'd0, 8'd0,
            9'd3, 9'd3, 9'd256, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R8 literal with m0", mk_long(10'h105, 1'b0, 7'd0, 8'd0,
            9'd255, 9'd124, 9'd256, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R8 literal twice", mk_long(10'h105, 1'b0, 7'd0, 8'd0,
            9'd255, 9'd255, 9'd256, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R9 lds in src1", mk_long(10'h105, 1'b0, 7'd0, 8'd0,
            9'd256, 9'd254, 9'd256, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R6 src2 unread", mk_long(10'h105, 1'b0, 7'd0, 8'd0,
            9'd3, 9'd256, 9'd5, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R6 src2 read", mk_long(10'h150, 1'b0, 7'd0, 8'd0,
            9'd3, 9'd256, 9'd5, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R9 lds in read src2", mk_long(10'h1C0, 1'b0, 7'd0, 8'd0,
            9'd254, 9'd256, 9'd254, 2'd0, 3'd0), 1'b1, 1'b0);
      apply("R5 invalid tag", {32'hFFFF_FFFF, 6'b111000, 26'h3FF_FFFF}, 1'b0, 1'b0);

      // R10: a new input must not reach the outputs before the next edge.
      w = mk_short(6'd10, 8'd11, 8'd12, 9'd13);
      apply("R10 first", w, 1'b0, 1'b0);
      @(negedge clk);
      instr_win = mk_long(10'h150, 1'b0, 7'd0, 8'd0, 9'd1, 9'd2, 9'd3, 2'd0, 3'd0);
      gen_new = 1'b1;
      #1;
      check_vec("R10 hold until edge", ref_dec(w, 1'b0, 1'b0));
      @(posedge clk);
      #1;
      check_vec("R10 after edge", ref_dec(instr_win, 1'b1, 1'b0));

      for (int n = 0; n < 400; n++) begin
         int kind = int'($urandom % 8);
         logic g = 1'($urandom);
         logic cf = 1'($urandom);
         logic [8:0] a = pick_src();
         logic [8:0] b = ($urandom % 4 == 0) ? a : pick_src();
         logic [8:0] c = pick_src();
         logic [9:0] op = ($urandom % 2 == 0) ? 10'd256 + 10'($urandom % 64) : 10'($urandom);
         logic [9:0] f = g ? op : {op[8:0], 1'($urandom)};
         if (kind < 3) begin
            w = {32'($urandom), 1'b0, 31'($urandom)};
            w[8:0] = a;
            apply("R1 R8 R9 random short", w, g, cf);
         end else if (kind < 7) begin
            w = mk_long(f, 1'($urandom), 7'($urandom), 8'($urandom), a, b, c,
                        2'($urandom), 3'($urandom));
            apply(g ? "R2 R4 R6 R7 R8 R9 random long" : "R2 R3 R6 R7 R8 R9 random long", w, g, cf);
         end else begin
            w = {32'($urandom), 1'b1, 31'($urandom)};
            if (w[31:26] == 6'b110100) w[26] = 1'b1;
            apply("R5 random invalid", w, g, cf);
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule